// File: doc/BRIEF.md
# Enable-Gated Set/Clear Latch Bank

This block holds three independent bits, each in a set/clear memory cell made only from inhibit gates. An inhibit gate drives its excitatory input AND NOT its inhibitory input. A fourth cell of the same structure acts as a power switch for the bank. Every gate in the three memory cells that would otherwise need a constant-high input takes the switch cell's true output instead. With the switch off, both the true and the complement output of every memory cell are forced to 0. A plain cross-coupled latch never shows that third output condition.

The model is binary and cycle-stepped. Each gate is one register, so one clock stands for one gate delay. All gates update together from the values of the previous cycle. Set, clear, on and off are pulses that must stay high for at least two clocks. Set and clear must never be high together on the same cell, and on and off must never be high together. After a state change the output that was high falls first, and the other output rises one clock later. When the bank comes back on, each memory cell starts cleared unless its set input is held through the turn-on.

Top module: `enable_gated_latch_bank`

## Requirements
- R1: Set pulse on an enabled cell: let k be the first clock edge that samples set_i[i] high. qn_o[i] is 0 after edge k+1, and q_o[i] is 1 after edge k+2. If the cell is already set, its outputs do not change.
- R2: Clear pulse on an enabled cell: let k be the first clock edge that samples clr_i[i] high. q_o[i] is 0 after edge k+1, and qn_o[i] is 1 after edge k+2. If the cell is already clear, its outputs do not change.
- R3: A stored value is held unchanged, with q_o[i] = ~qn_o[i], for as long as no pulse arrives and the bank stays on. This holds for any pulse of two or more clocks.
- R4: While rst_ni is low, and directly after it is released, the switch is off and every q_o and qn_o bit is 0.
- R5: An off_i pulse drives every q_o and qn_o bit to 0 within five clocks of the first sampling edge. While the bank is off, set_i and clr_i have no effect on the outputs.
- R6: An on_i pulse with no set held re-enables the bank within five clocks of the first sampling edge. Every cell then reads q_o=0 and qn_o=1.
- R7: A cell whose set_i is held high through a turn-on comes up set (q_o=1, qn_o=0). The other cells come up clear.
- R8: Cells are independent: a pulse on one cell leaves the other cells' outputs unchanged.
- R9: On a state change the falling output drops before the rising output rises. q_o[i] and qn_o[i] are never both 1, in the memory cells or in the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Gate-delay step clock |
| rst_ni | input | 1 | Asynchronous active-low reset, bank off |
| on_i | input | 1 | Switch-on pulse, at least 2 clocks |
| off_i | input | 1 | Switch-off pulse, at least 2 clocks |
| set_i | input | NUM_CELLS | Per-cell set pulse, at least 2 clocks |
| clr_i | input | NUM_CELLS | Per-cell clear pulse, at least 2 clocks |
| q_o | output | NUM_CELLS | Stored bit of each cell |
| qn_o | output | NUM_CELLS | Complement of each cell, 0 while off |

## Verification
The case hardest to reach from the ports is a cell whose set is held across a turn-on. The set pulse has to overlap the switch's own three-gate rise and then the enable stagger inside the cell. The stimulus raises set_i while the bank is still off, pulses on_i, and holds set_i for seven more clocks. Only then does it release set_i and read the outputs. A sweep over all 64 ordered pairs of stored patterns checks the midway state in which both outputs are low. Every set, clear and no-change transition is covered in each cell at the same time.

// File: rtl/latch_bank_pkg.sv
package latch_bank_pkg;
  typedef struct packed {
    logic q;
    logic qn;
  } cell_out_t;
endpackage

// File: rtl/inhibit_gate.sv
module inhibit_gate #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exc_i,
  input  logic inh_i,
  output logic y_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= RST_VAL;
    else         y_o <= exc_i & ~inh_i;
  end
endmodule

// File: rtl/sr_cell.sv
module sr_cell
  import latch_bank_pkg::*;
#(
  parameter bit ON_AT_RESET = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      set_i,
  input  logic      clr_i,
  output cell_out_t out_o
);
  logic set_n, clr_n, en_lag, q, qn;

  // input inverters: inhibit gates excited by the enable
  inhibit_gate #(.RST_VAL(ON_AT_RESET)) u_set_inv (
    .clk_i, .rst_ni, .exc_i(en_i), .inh_i(set_i), .y_o(set_n));

  // one-gate stagger so the complement side wins on re-enable
  inhibit_gate #(.RST_VAL(ON_AT_RESET)) u_en_lag (
    .clk_i, .rst_ni, .exc_i(en_i), .inh_i(1'b0), .y_o(en_lag));

  inhibit_gate #(.RST_VAL(ON_AT_RESET)) u_clr_inv (
    .clk_i, .rst_ni, .exc_i(en_lag), .inh_i(clr_i), .y_o(clr_n));

  // cross-coupled pair
  inhibit_gate #(.RST_VAL(ON_AT_RESET)) u_qn (
    .clk_i, .rst_ni, .exc_i(set_n), .inh_i(q), .y_o(qn));

  inhibit_gate #(.RST_VAL(1'b0)) u_q (
    .clk_i, .rst_ni, .exc_i(clr_n), .inh_i(qn), .y_o(q));

  assign out_o = cell_out_t'{q: q, qn: qn};
endmodule

// File: rtl/enable_gated_latch_bank.sv
module enable_gated_latch_bank
  import latch_bank_pkg::*;
#(
  parameter int NUM_CELLS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 on_i,
  input  logic                 off_i,
  input  logic [NUM_CELLS-1:0] set_i,
  input  logic [NUM_CELLS-1:0] clr_i,
  output logic [NUM_CELLS-1:0] q_o,
  output logic [NUM_CELLS-1:0] qn_o
);
  cell_out_t sw_out;
  cell_out_t cell_out [NUM_CELLS];
  logic      sw_en;

  // switch cell: constant-high enable, comes out of reset off
  sr_cell #(.ON_AT_RESET(1'b1)) u_switch (
    .clk_i, .rst_ni, .en_i(1'b1), .set_i(on_i), .clr_i(off_i), .out_o(sw_out));

  assign sw_en = sw_out.q;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    sr_cell #(.ON_AT_RESET(1'b0)) u_cell (
      .clk_i, .rst_ni, .en_i(sw_en), .set_i(set_i[i]), .clr_i(clr_i[i]),
      .out_o(cell_out[i]));
    assign q_o[i]  = cell_out[i].q;
    assign qn_o[i] = cell_out[i].qn;
  end
endmodule

// File: rtl/latch_bank_checker.sv
module latch_bank_checker #(
  parameter int NUM_CELLS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 sw_qn_i,
  input logic [NUM_CELLS-1:0] set_i,
  input logic [NUM_CELLS-1:0] clr_i,
  input logic [NUM_CELLS-1:0] q_i,
  input logic [NUM_CELLS-1:0] qn_i
);
  a_r9_switch_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && sw_qn_i));

  a_r5_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i) && !$past(en_i, 2) && !$past(en_i, 3))
    |-> (q_i == '0 && qn_i == '0));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    a_r9_not_both_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(q_i[i] && qn_i[i]));

    a_r1_true_rises_after_comp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(q_i[i]) |-> !$past(qn_i[i]));

    a_r2_comp_rises_after_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(qn_i[i]) |-> !$past(q_i[i]));

    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i) && $past(en_i, 2) && $past(en_i, 3) &&
       !set_i[i] && !$past(set_i[i]) && !$past(set_i[i], 2) && !$past(set_i[i], 3) &&
       !clr_i[i] && !$past(clr_i[i]) && !$past(clr_i[i], 2) && !$past(clr_i[i], 3))
      |-> ($stable(q_i[i]) && $stable(qn_i[i])));
  end
endmodule

bind enable_gated_latch_bank latch_bank_checker #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sw_en), .sw_qn_i(sw_out.qn),
  .set_i(set_i), .clr_i(clr_i), .q_i(q_o), .qn_i(qn_o));

// File: tb/enable_gated_latch_bank_test.sv
module enable_gated_latch_bank_test;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         on_i = 1'b0, off_i = 1'b0;
  logic [N-1:0] set_i = '0, clr_i = '0;
  logic [N-1:0] q_o, qn_o;
  int           n_chk = 0, n_bad = 0;
  logic [N-1:0] held;

  always #2 clk = ~clk;

  enable_gated_latch_bank #(.NUM_CELLS(N)) uut (
    .clk_i(clk), .rst_ni, .on_i, .off_i, .set_i, .clr_i, .q_o, .qn_o);

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [N-1:0] eq, logic [N-1:0] eqn);
    n_chk++;
    if (q_o !== eq || qn_o !== eqn || (q_o & qn_o) !== '0) begin
      n_bad++;
      $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", req, q_o, qn_o, eq, eqn);
    end
  endtask

  // two-clock pulse on enabled bank, checks midway and final state
  task automatic write(logic [N-1:0] s, logic [N-1:0] c, logic [N-1:0] prev,
                       logic [N-1:0] nxt, string req);
    logic [N-1:0] chg;
    if ((s & c) != '0) begin
      $display("ILLEGAL set/clr overlap %b skipped", s & c);
      return;
    end
    chg = prev ^ nxt;
    set_i = s; clr_i = c;
    tick(2);
    set_i = '0; clr_i = '0;
    chk({req, " R9 midway"}, prev & ~chg, ~prev & ~chg);
    tick(1);
    chk({req, " final"}, nxt, ~nxt);
  endtask

  task automatic switch_pulse(bit on);
    if (on) on_i = 1'b1; else off_i = 1'b1;
    tick(2);
    on_i = 1'b0; off_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R4 in reset", '0, '0);
    rst_ni = 1'b1;
    tick(1);
    chk("R4 after reset", '0, '0);

    // R5: pulses while off are ignored
    set_i = '1; tick(2); set_i = '0;
    tick(1); chk("R5 set while off", '0, '0);
    clr_i = 3'b010; tick(2); clr_i = '0;
    tick(4); chk("R5 clr while off", '0, '0);

    // R6: turn on, all cells clear
    switch_pulse(1'b1); tick(3);
    chk("R6 resume clear", '0, '1);

    // R1 R2 R8: all ordered pattern pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        held = q_o;
        write(a[N-1:0], ~a[N-1:0], held, a[N-1:0], "R1/R2 prep");
        write(b[N-1:0], ~b[N-1:0], a[N-1:0], b[N-1:0], "R1 R2 R8 pair");
        tick(4);
        chk("R3 hold", b[N-1:0], ~b[N-1:0]);
      end
    end

    // R8: single-cell pulse leaves others alone
    write(3'b000, 3'b010, 3'b111, 3'b101, "R2 R8 single clr");
    write(3'b010, 3'b000, 3'b101, 3'b111, "R1 R8 single set");
    write(3'b001, 3'b000, 3'b111, 3'b111, "R1 already set");
    write(3'b000, 3'b010, 3'b111, 3'b101, "R2 single");
    write(3'b000, 3'b010, 3'b101, 3'b101, "R2 already clear");

    // R5: off clears held pattern
    switch_pulse(1'b0); tick(3);
    chk("R5 off clears", '0, '0);
    tick(10); chk("R5 stays off", '0, '0);

    // R7: set held through turn-on
    set_i = 3'b010;
    tick(1);
    switch_pulse(1'b1);
    tick(7);
    set_i = '0;
    tick(3);
    chk("R7 set through turn-on", 3'b010, 3'b101);
    tick(6);
    chk("R3 hold after R7", 3'b010, 3'b101);

    // R6 again after off/on cycle
    switch_pulse(1'b0); tick(3);
    chk("R5 second off", '0, '0);
    switch_pulse(1'b1); tick(3);
    chk("R6 second resume", '0, '1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule